// File: doc/BRIEF.md
# OLED Controller Command Interpreter

This block sits behind an already-decoded I2C target and interprets the bytes of a write transaction meant for a monochrome OLED panel controller. Every transaction opens with a control byte that chooses command mode or data mode. In data mode each byte goes straight into a 132-column by 8-page display RAM through a one-cycle write port, and the column pointer advances after each write. In command mode a single command byte is decoded. It can move the column or page pointer, change a display flag, reset the start line, or announce a parameter byte that is then thrown away. After that one command the block goes back to waiting for a control byte.

The display flags are enable, inverse, entire-display-on and mirror. They are driven out as registered levels for the panel scan logic. Each accepted RAM write also pulses a redraw request. Malformed control bytes and unknown commands raise a one-cycle error pulse, and the block stays usable afterwards. Stop and start strobes from the bus target end the current mode. All outputs are registered, and every update takes effect on the clock edge that samples the input byte.

Top module: `oled_cmd_decoder`

## Requirements
- R1: In idle mode, byte 0x80 enters command mode and byte 0x40 enters data mode. Any other byte pulses `proto_err` for one cycle, starting the cycle after the byte, and leaves the block idle.
- R2: In data mode, a byte whose column pointer is below 132 produces a one-cycle `ram_we` in the following cycle. That write carries `ram_addr` = page*132 + column and `ram_wdata` = the byte, and the column pointer then increments.
- R3: In data mode, a byte that arrives while the column pointer is 132 or more produces no write and leaves the pointers unchanged.
- R4: A command byte (one that is not a pending parameter) returns the block to idle, so the next byte is read as a control byte.
- R5: Commands 0x00..0x0F replace bits [3:0] of the 8-bit column pointer with the command's bits [3:0]. Commands 0x10..0x20 replace bits [7:4] of the column pointer with the command's bits [3:0].
- R6: Commands 0xB0..0xBF load the page pointer with the command's bits [2:0].
- R7: Command bit 0 is the new flag value for four command pairs: 0xAE/0xAF drive `disp_on`, 0xA6/0xA7 drive `disp_invert`, 0xA4/0xA5 drive `disp_all_on`, and 0xA0/0xA1 drive `disp_mirror`.
- R8: Commands 0x81, 0xA8, 0xAD, 0xD3, 0xD5, 0xD8, 0xD9, 0xDA and 0xDB return the block to idle and mark the next byte as a parameter. A control byte is still needed. Once the block is in command mode again, the first byte is discarded with no effect, the block stays in command mode, and the byte after it is decoded as a command.
- R9: Commands 0x40..0x7F set `disp_start_line` to 0. Commands 0xC0..0xC8 and 0xE3 have no effect. Every command not listed in R5 to R9 pulses `proto_err` for one cycle.
- R10: A cycle with `xfer_stop` or `xfer_start` high returns the block to idle. A byte presented in that same cycle is discarded. A pending parameter skip survives this.
- R11: A synchronous active-high reset clears both pointers, the start line, all flags, `ram_we`, `redraw` and `proto_err`, puts the block in idle, and cancels any pending skip.
- R12: `redraw` pulses in exactly the cycles in which `ram_we` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | A received write byte is present this cycle |
| rx_byte | input | 8 | Received byte |
| xfer_start | input | 1 | Transaction start strobe |
| xfer_stop | input | 1 | Transaction stop strobe |
| ram_we | output | 1 | Display RAM write enable |
| ram_addr | output | AW (11) | Display RAM byte address |
| ram_wdata | output | 8 | Display RAM write data |
| redraw | output | 1 | Redraw request pulse |
| proto_err | output | 1 | Bad control byte or unknown command pulse |
| disp_on | output | 1 | Display enable flag |
| disp_invert | output | 1 | Inverse video flag |
| disp_all_on | output | 1 | Entire-display-on flag |
| disp_mirror | output | 1 | Horizontal mirror flag |
| disp_start_line | output | LW (6) | Display start line |

## Verification
The checker watches several rules on every cycle:
- Each RAM write comes from a data-mode byte, stays inside the RAM, and coincides with a redraw pulse.
- A strobe or a decoded command always returns the mode to idle.
- A skipped parameter keeps the block in command mode.
- The flags never change without a command-mode byte.
- Every error pulse traces back to a received byte.

Only the bench's scenarios can show the decoded effects of particular bytes. These are the exact column and page values after nibble and page commands, the point where writes stop at the end of a row, the skip that carries across a stop, and which command values are errors and which are silent no-ops.

// File: rtl/oled_pkg.sv
package oled_pkg;
  typedef enum logic [1:0] {M_IDLE = 2'd0, M_DATA = 2'd1, M_CMD = 2'd2} mode_t;

  typedef enum logic [2:0] {
    K_COL_LO, K_COL_HI, K_START, K_PAGE, K_FLAG, K_PARAM, K_NOP, K_BAD
  } kind_t;

  typedef enum logic [1:0] {F_ENABLE, F_INVERT, F_ALLON, F_MIRROR} flag_t;

  localparam logic [7:0] CTL_CMD  = 8'h80;
  localparam logic [7:0] CTL_DATA = 8'h40;
endpackage

// File: rtl/oled_cmd_classify.sv
module oled_cmd_classify
  import oled_pkg::*;
(
  input  logic [7:0] cmd,
  output kind_t      kind,
  output flag_t      flag
);
  always_comb begin
    kind = K_BAD;
    flag = F_ENABLE;
    if (cmd <= 8'h0F)                     kind = K_COL_LO;
    else if (cmd <= 8'h20)                kind = K_COL_HI;
    else if (cmd >= 8'h40 && cmd <= 8'h7F) kind = K_START;
    else if (cmd[7:4] == 4'hB)            kind = K_PAGE;
    else if (cmd >= 8'hC0 && cmd <= 8'hC8) kind = K_NOP;
    else begin
      case (cmd)
        8'hA0, 8'hA1: begin kind = K_FLAG; flag = F_MIRROR; end
        8'hA4, 8'hA5: begin kind = K_FLAG; flag = F_ALLON;  end
        8'hA6, 8'hA7: begin kind = K_FLAG; flag = F_INVERT; end
        8'hAE, 8'hAF: begin kind = K_FLAG; flag = F_ENABLE; end
        8'h81, 8'hA8, 8'hAD, 8'hD3, 8'hD5,
        8'hD8, 8'hD9, 8'hDA, 8'hDB:    kind = K_PARAM;
        8'hE3:                          kind = K_NOP;
        default:                        kind = K_BAD;
      endcase
    end
  end
endmodule

// File: rtl/oled_addr_gen.sv
module oled_addr_gen #(
  parameter int COLS = 132,
  parameter int CW   = 8,
  parameter int PW   = 3,
  parameter int AW   = 11
) (
  input  logic [CW-1:0] col,
  input  logic [PW-1:0] page,
  output logic [AW-1:0] addr,
  output logic          in_range
);
  assign addr     = AW'(page) * AW'(COLS) + AW'(col);
  assign in_range = (col < CW'(COLS));
endmodule

// File: rtl/oled_cmd_decoder.sv
module oled_cmd_decoder
  import oled_pkg::*;
#(
  parameter int  COLS  = 132,
  parameter int  PAGES = 8,
  parameter int  LINES = 64,
  localparam int AW    = $clog2(COLS * PAGES),
  localparam int LW    = $clog2(LINES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_valid,
  input  logic [7:0]    rx_byte,
  input  logic          xfer_start,
  input  logic          xfer_stop,
  output logic          ram_we,
  output logic [AW-1:0] ram_addr,
  output logic [7:0]    ram_wdata,
  output logic          redraw,
  output logic          proto_err,
  output logic          disp_on,
  output logic          disp_invert,
  output logic          disp_all_on,
  output logic          disp_mirror,
  output logic [LW-1:0] disp_start_line
);
  localparam int CW = 8;
  localparam int PW = $clog2(PAGES);

  mode_t          mode_q;
  logic           skip_q;
  logic [CW-1:0]  col_q;
  logic [PW-1:0]  page_q;
  kind_t          kind;
  flag_t          flag;
  logic [AW-1:0]  wr_addr;
  logic           in_range;

  oled_cmd_classify u_classify (
    .cmd  (rx_byte),
    .kind (kind),
    .flag (flag)
  );

  oled_addr_gen #(.COLS(COLS), .CW(CW), .PW(PW), .AW(AW)) u_addr (
    .col      (col_q),
    .page     (page_q),
    .addr     (wr_addr),
    .in_range (in_range)
  );

  always_ff @(posedge clk) begin
    ram_we    <= 1'b0;
    redraw    <= 1'b0;
    proto_err <= 1'b0;
    if (rst) begin
      mode_q          <= M_IDLE;
      skip_q          <= 1'b0;
      col_q           <= '0;
      page_q          <= '0;
      ram_addr        <= '0;
      ram_wdata       <= '0;
      disp_on         <= 1'b0;
      disp_invert     <= 1'b0;
      disp_all_on     <= 1'b0;
      disp_mirror     <= 1'b0;
      disp_start_line <= '0;
    end else if (xfer_stop || xfer_start) begin
      mode_q <= M_IDLE;
    end else if (rx_valid) begin
      case (mode_q)
        M_IDLE: begin
          if (rx_byte == CTL_CMD)       mode_q <= M_CMD;
          else if (rx_byte == CTL_DATA) mode_q <= M_DATA;
          else                          proto_err <= 1'b1;
        end
        M_DATA: begin
          if (in_range) begin
            ram_we    <= 1'b1;
            redraw    <= 1'b1;
            ram_addr  <= wr_addr;
            ram_wdata <= rx_byte;
            col_q     <= col_q + 1'b1;
          end
        end
        M_CMD: begin
          if (skip_q) begin
            skip_q <= 1'b0;
          end else begin
            mode_q <= M_IDLE;
            case (kind)
              K_COL_LO: col_q[3:0] <= rx_byte[3:0];
              K_COL_HI: col_q[7:4] <= rx_byte[3:0];
              K_START:  disp_start_line <= '0;
              K_PAGE:   page_q <= rx_byte[PW-1:0];
              K_FLAG: begin
                case (flag)
                  F_ENABLE: disp_on     <= rx_byte[0];
                  F_INVERT: disp_invert <= rx_byte[0];
                  F_ALLON:  disp_all_on <= rx_byte[0];
                  F_MIRROR: disp_mirror <= rx_byte[0];
                  default:  ;
                endcase
              end
              K_PARAM:  skip_q <= 1'b1;
              K_NOP:    ;
              default:  proto_err <= 1'b1;
            endcase
          end
        end
        default: mode_q <= M_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/oled_cmd_checker.sv
module oled_cmd_checker
  import oled_pkg::*;
#(
  parameter int COLS  = 132,
  parameter int PAGES = 8,
  parameter int AW    = 11
) (
  input logic          clk,
  input logic          rst,
  input logic          rx_valid,
  input logic          xfer_start,
  input logic          xfer_stop,
  input logic          ram_we,
  input logic [AW-1:0] ram_addr,
  input logic          redraw,
  input logic          proto_err,
  input logic [3:0]    flags,
  input mode_t         mode_q,
  input logic          skip_q
);
  logic strobe;
  assign strobe = xfer_start || xfer_stop;

  p_addr_bound_r2: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> (ram_addr < AW'(COLS * PAGES)));

  p_write_cause_r2: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> $past(rx_valid && !strobe && mode_q == M_DATA));

  p_redraw_with_we_r12: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> redraw);

  p_we_with_redraw_r12: assert property (@(posedge clk) disable iff (rst)
    redraw |-> ram_we);

  p_strobe_idle_r10: assert property (@(posedge clk) disable iff (rst)
    strobe |=> mode_q == M_IDLE);

  p_err_cause_r1: assert property (@(posedge clk) disable iff (rst)
    proto_err |-> ($past(rx_valid) && !ram_we));

  p_cmd_returns_r4: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !strobe && mode_q == M_CMD && !skip_q) |=> mode_q == M_IDLE);

  p_skip_stays_r8: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !strobe && mode_q == M_CMD && skip_q) |=> (mode_q == M_CMD && !skip_q));

  p_flags_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !(rx_valid && mode_q == M_CMD) |=> $stable(flags));
endmodule

bind oled_cmd_decoder oled_cmd_checker #(.COLS(COLS), .PAGES(PAGES), .AW(AW)) u_checker (
  .clk        (clk),
  .rst        (rst),
  .rx_valid   (rx_valid),
  .xfer_start (xfer_start),
  .xfer_stop  (xfer_stop),
  .ram_we     (ram_we),
  .ram_addr   (ram_addr),
  .redraw     (redraw),
  .proto_err  (proto_err),
  .flags      ({disp_on, disp_invert, disp_all_on, disp_mirror}),
  .mode_q     (mode_q),
  .skip_q     (skip_q)
);

// File: tb/oled_cmd_decoder_bench.sv
module oled_cmd_decoder_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_byte = 8'h00;
  logic        xfer_start = 1'b0;
  logic        xfer_stop = 1'b0;
  logic        ram_we, redraw, proto_err;
  logic [10:0] ram_addr;
  logic [7:0]  ram_wdata;
  logic        disp_on, disp_invert, disp_all_on, disp_mirror;
  logic [5:0]  disp_start_line;

  int n_tests = 0;
  int n_fail = 0;
  bit cmp_en = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  oled_cmd_decoder u_oled_cmd_decoder (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .xfer_start(xfer_start), .xfer_stop(xfer_stop),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .redraw(redraw), .proto_err(proto_err),
    .disp_on(disp_on), .disp_invert(disp_invert), .disp_all_on(disp_all_on),
    .disp_mirror(disp_mirror), .disp_start_line(disp_start_line)
  );

  // Behavioural reference: mode 0 idle, 1 data, 2 command
  int m_mode, m_col, m_page, m_skip, m_line;
  int m_on, m_inv, m_all, m_mir;
  int e_we, e_addr, e_wd, e_err;

  always @(posedge clk) begin
    int b;
    b = rx_byte;
    e_we = 0; e_err = 0;
    if (rst) begin
      m_mode = 0; m_col = 0; m_page = 0; m_skip = 0; m_line = 0;
      m_on = 0; m_inv = 0; m_all = 0; m_mir = 0; e_addr = 0; e_wd = 0;
    end else if (xfer_stop || xfer_start) begin
      m_mode = 0;
    end else if (rx_valid) begin
      if (m_mode == 0) begin
        if (b == 'h80) m_mode = 2;
        else if (b == 'h40) m_mode = 1;
        else e_err = 1;
      end else if (m_mode == 1) begin
        if (m_col < 132) begin
          e_we = 1; e_addr = m_page * 132 + m_col; e_wd = b; m_col++;
        end
      end else if (m_skip != 0) begin
        m_skip = 0;
      end else begin
        m_mode = 0;
        if (b < 16) m_col = (m_col / 16) * 16 + b % 16;
        else if (b <= 'h20) m_col = (b % 16) * 16 + m_col % 16;
        else if (b >= 'h40 && b < 'h80) m_line = 0;
        else if (b >= 'hB0 && b < 'hC0) m_page = b % 8;
        else if (b == 'hAE || b == 'hAF) m_on = b % 2;
        else if (b == 'hA6 || b == 'hA7) m_inv = b % 2;
        else if (b == 'hA4 || b == 'hA5) m_all = b % 2;
        else if (b == 'hA0 || b == 'hA1) m_mir = b % 2;
        else if (b == 'h81 || b == 'hA8 || b == 'hAD || b == 'hD3 || b == 'hD5 ||
                 b == 'hD8 || b == 'hD9 || b == 'hDA || b == 'hDB) m_skip = 1;
        else if ((b >= 'hC0 && b <= 'hC8) || b == 'hE3) m_skip = 0;
        else e_err = 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en && !done) begin
      chk(ram_we == e_we[0], "R2|R3", "ram_we", ram_we, e_we);
      if (e_we != 0) begin
        chk(ram_addr == e_addr[10:0], "R2|R5|R6", "ram_addr", ram_addr, e_addr);
        chk(ram_wdata == e_wd[7:0], "R2", "ram_wdata", ram_wdata, e_wd);
      end
      chk(redraw == e_we[0], "R12", "redraw", redraw, e_we);
      chk(proto_err == e_err[0], "R1|R9", "proto_err", proto_err, e_err);
      chk({disp_on, disp_invert, disp_all_on, disp_mirror} ==
          {m_on[0], m_inv[0], m_all[0], m_mir[0]}, "R7|R8", "flags",
          {disp_on, disp_invert, disp_all_on, disp_mirror},
          {m_on[0], m_inv[0], m_all[0], m_mir[0]});
      chk(disp_start_line == m_line[5:0], "R9", "start_line", disp_start_line, m_line);
    end
  end

  // Each task is entered at a falling edge and returns at one.
  task automatic put(input logic [7:0] b);
    rx_valid = 1'b1; rx_byte = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic cmd(input logic [7:0] c);
    put(8'h80); put(c);
  endtask

  task automatic stop_strobe(input bit with_byte, input logic [7:0] b);
    xfer_stop = 1'b1; rx_valid = with_byte; rx_byte = b;
    @(negedge clk);
    xfer_stop = 1'b0; rx_valid = 1'b0;
  endtask

  task automatic check_reset_state();
    chk(!ram_we && !redraw && !proto_err, "R11", "pulses", {ram_we, redraw, proto_err}, 0);
    chk({disp_on, disp_invert, disp_all_on, disp_mirror} == 4'b0, "R11", "flags",
        {disp_on, disp_invert, disp_all_on, disp_mirror}, 0);
    chk(disp_start_line == 6'd0, "R11", "start_line", disp_start_line, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    cmp_en = 1'b1;
    check_reset_state();
    // R1 and R2: data mode after reset, writes from column 0 of page 0
    put(8'h40); put(8'h11); put(8'h22); put(8'h33);
    stop_strobe(1'b0, 8'h00);
    // R5, R6, R4: page 3, column 0x83, then R3 drops writes past the row end
    cmd(8'hB3); cmd(8'h03); cmd(8'h18);
    put(8'h40); put(8'hAA); put(8'hBB); put(8'hCC);
    stop_strobe(1'b0, 8'h00);
    // R5: 0x20 clears the high nibble, then write at column 5 of page 3
    cmd(8'h20); cmd(8'h05);
    put(8'h40); put(8'h77);
    stop_strobe(1'b0, 8'h00);
    // R7: every flag set and cleared
    cmd(8'hAF); cmd(8'hA7); cmd(8'hA5); cmd(8'hA1);
    cmd(8'hA6); cmd(8'hA4); cmd(8'hAE); cmd(8'hA0);
    // R8: parameter byte swallowed, next byte decoded as a command
    cmd(8'h81); put(8'h80); put(8'hAF); put(8'hA7);
    cmd(8'hD5); put(8'h80); put(8'h12); put(8'hA1);
    // R10: skip survives a stop
    cmd(8'hDB); stop_strobe(1'b0, 8'h00); put(8'h80); put(8'hA5); put(8'hA4);
    // R1: bad control bytes; R9: unknown commands, no-ops, start line
    put(8'h12); put(8'hFF);
    cmd(8'hFF); cmd(8'h30); cmd(8'hA2);
    cmd(8'hE3); cmd(8'hC5); cmd(8'hC8); cmd(8'h45); cmd(8'hC9);
    // R4: byte after a command is a control byte (0x55 flagged)
    cmd(8'hB1); put(8'h55);
    // R10: stop in data mode, then a byte is a control byte
    put(8'h40); put(8'h01); stop_strobe(1'b0, 8'h00); put(8'h99);
    // R10: byte with a simultaneous stop is discarded
    put(8'h40); stop_strobe(1'b1, 8'h40); put(8'h5A);
    // R10: start strobe also returns to idle
    put(8'h40); put(8'h02);
    xfer_start = 1'b1; @(negedge clk); xfer_start = 1'b0;
    put(8'h40); put(8'h03);
    stop_strobe(1'b0, 8'h00);
    // R3: last page, column 128, six bytes give four writes
    cmd(8'hB7); cmd(8'h00); cmd(8'h18);
    put(8'h40);
    for (int i = 0; i < 6; i++) put(8'hE0 + 8'(i));
    stop_strobe(1'b0, 8'h00);
    // R11: reset in the middle of data mode with a skip pending elsewhere
    cmd(8'hAF); cmd(8'hA8); put(8'h40);
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    check_reset_state();
    put(8'h40); put(8'hC3);
    @(negedge clk);
    chk(ram_we == 1'b0, "R11", "idle write", ram_we, 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule